// File: doc/BRIEF.md
# Sample-Period Interval Timer

This block raises a periodic event counted in audio sample periods. A strobe input pulses for one clock in each sample period. The timer counts these strobes. When the count reaches a programmed terminal value, the timer emits a one-clock event pulse, clears its counter and begins the next period. The event pulse goes to the pending register of an interrupt unit. Whether it becomes an interrupt is decided there by that unit's enable, not by this block.

Software programs the period through a 16-bit host register. Only the low ten bits hold the rate. A rate of zero selects the longest period of 1024 sample periods. The written rate is held as a shadow value and is copied into the active terminal count only when the current period wraps. After a rate change, the first event can therefore still arrive on the old schedule, up to 1024 sample periods later. Rates from 1 to 4 are of little practical use, but they still give exact, repeatable periods.

All pins are plain control and status signals. No stream interface is present, so no valid/ready handshake or back-pressure applies.

Top module: `sample_interval_timer`

## Requirements
- R1: After reset, the register reads 0x0000 and the event output is low. With no write, the first event follows the 1024th sample tick.
- R2: Bits 9:0 of the register read back the last value written to bits 9:0. Bits 15:10 always read as zero, and whatever is written to them has no effect.
- R3: The event output is high for exactly one clock. That clock follows the clock edge at which the tick that completes the period was sampled.
- R4: A rate N in the range 1 to 1023 gives one event every N sample ticks.
- R5: A rate of 0 gives one event every 1024 sample ticks.
- R6: A rate written in the middle of a period does not change that period. The new rate applies from the period that starts after the next event.
- R7: A rate of 1 gives an event on every sample tick. Rates 2 to 4 give exact periods of 2 to 4 ticks.
- R8: Clock cycles in which the sample tick is low do not advance the count, whatever the gap between ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Writes reg_wr_data into the rate register |
| reg_wr_data | input | 16 | Write data; only bits 9:0 are kept |
| reg_rd_data | output | 16 | Read-back of the rate register, upper bits zero |
| sample_tick | input | 1 | One-clock strobe, once per sample period |
| timer_event | output | 1 | One-clock pulse at each terminal count |

## Verification
The bench writes a rate in the middle of a running period and checks that the remaining count of the old period holds. A design that loaded the rate at once would fire early. The bench also checks that a zero rate measures 1024 ticks rather than 0 or 1, and that a rate of 1 fires on every tick. A design with an off-by-one in the terminal compare would show as a period one tick too long or too short. Writes with the upper bits set must give back only the low field, and the measured period must match that field alone. Ticks separated by idle gaps of different lengths must still give the exact period. A counter that advanced on the clock instead of the tick would fail this check.

// File: rtl/sit_pkg.sv
package sit_pkg;
  parameter int unsigned SIT_REG_W  = 16;
  parameter int unsigned SIT_RATE_W = 10;
endpackage

// File: rtl/sit_rate_reg.sv
module sit_rate_reg #(
  parameter int unsigned REG_W  = sit_pkg::SIT_REG_W,
  parameter int unsigned RATE_W = sit_pkg::SIT_RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [RATE_W-1:0] rate_o,
  output logic [REG_W-1:0]  rd_data
);
  localparam int unsigned PAD_W = REG_W - RATE_W;

  logic [RATE_W-1:0] rate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rate_q <= '0;
    else if (wr_en) rate_q <= wr_data[RATE_W-1:0];
  end

  assign rate_o  = rate_q;
  assign rd_data = {{PAD_W{1'b0}}, rate_q};

  // R2: a write is visible on the read port in the next cycle
  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[RATE_W-1:0] == $past(wr_data[RATE_W-1:0]));
endmodule

// File: rtl/sit_period_counter.sv
module sit_period_counter #(
  parameter int unsigned RATE_W = sit_pkg::SIT_RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate_i,
  output logic              evt_o
);
  localparam int unsigned CW = RATE_W + 1;
  localparam logic [CW-1:0] FULL = CW'(1) << RATE_W;

  logic [CW-1:0] count_q, term_q, count_inc, term_next;
  logic          hit, evt_q;

  assign term_next = (rate_i == '0) ? FULL : {1'b0, rate_i};
  assign count_inc = count_q + CW'(1);
  assign hit       = tick && (count_inc == term_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      term_q  <= FULL;
      evt_q   <= 1'b0;
    end else begin
      evt_q <= hit;
      if (hit) begin
        count_q <= '0;
        term_q  <= term_next;
      end else if (tick) begin
        count_q <= count_inc;
      end
    end
  end

  assign evt_o = evt_q;

  assert_evt_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> $past(tick));
  assert_evt_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> count_q == '0);
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count_q < term_q);
  assert_term_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    term_q != '0 && term_q <= FULL);
  assert_term_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(term_q) |-> evt_q);
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count_q));
endmodule

// File: rtl/sample_interval_timer.sv
module sample_interval_timer #(
  parameter int unsigned REG_W  = sit_pkg::SIT_REG_W,
  parameter int unsigned RATE_W = sit_pkg::SIT_RATE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic             sample_tick,
  output logic             timer_event
);
  logic [RATE_W-1:0] rate;

  sit_rate_reg #(.REG_W(REG_W), .RATE_W(RATE_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
    .rate_o(rate), .rd_data(reg_rd_data)
  );

  sit_period_counter #(.RATE_W(RATE_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .rate_i(rate),
    .evt_o(timer_event)
  );
endmodule

// File: tb/sample_interval_timer_test.sv
`timescale 1ns/1ps
module sample_interval_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [15:0] reg_wr_data = '0;
  logic [15:0] reg_rd_data;
  logic        sample_tick = 1'b0;
  logic        timer_event;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam int NV = 7;
  localparam logic [15:0] VEC_W [NV] =
    '{16'h0005, 16'hFC03, 16'h0001, 16'h03FF, 16'h0400, 16'h0002, 16'h0004};
  localparam int VEC_RD [NV] = '{5, 3, 1, 1023, 0, 2, 4};
  localparam int VEC_P  [NV] = '{5, 3, 1, 1023, 1024, 2, 4};

  always #2 clk = ~clk;

  sample_interval_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .sample_tick(sample_tick), .timer_event(timer_event)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [15:0] v);
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = v;
    @(negedge clk); reg_wr_en = 1'b0; reg_wr_data = '0;
  endtask

  // one tick followed by gap idle cycles; returns event seen after the tick
  task automatic tick_once(input int gap, output bit e);
    @(negedge clk); sample_tick = 1'b1;
    @(negedge clk); sample_tick = 1'b0;
    e = timer_event;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      if (timer_event) check(0, "R3 event longer than one cycle", 1, 0);
    end
  endtask

  task automatic ticks_to_event(input int gap, output int n);
    bit e;
    n = 0;
    do begin
      tick_once(gap, e);
      n++;
    end while (!e && n < 2000);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    bit e;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(reg_rd_data == 16'h0000, "R1 reset readback", reg_rd_data, 0);
    check(timer_event == 1'b0, "R1 reset event", timer_event, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(reg_rd_data == 16'h0000, "R1 readback after reset", reg_rd_data, 0);

    // R6: mid-period write does not disturb the 1024-tick period in flight
    for (int i = 0; i < 10; i++) begin
      tick_once(1, e);
      check(!e, "R1 no early event", e, 0);
    end
    write_reg(16'h0003);
    ticks_to_event(1, n);
    check(n == 1014, "R6 old period completes (R1 R5)", n, 1014);
    ticks_to_event(1, n);
    check(n == 3, "R6 new rate after wrap", n, 3);

    // table walk
    for (int i = 0; i < NV; i++) begin
      write_reg(VEC_W[i]);
      check(int'(reg_rd_data) == VEC_RD[i], "R2 readback", reg_rd_data, VEC_RD[i]);
      ticks_to_event(1, n);
      ticks_to_event(1, n);
      check(n == VEC_P[i], "R4 R5 R7 period", n, VEC_P[i]);
      ticks_to_event(1, n);
      check(n == VEC_P[i], "R4 R5 R7 repeat period", n, VEC_P[i]);
    end

    // R7: rate 1 fires on every tick
    write_reg(16'h0001);
    ticks_to_event(1, n);
    for (int i = 0; i < 4; i++) begin
      tick_once(1, e);
      check(e, "R7 rate 1 every tick", e, 1);
    end

    // R8: irregular gaps between ticks
    write_reg(16'h0007);
    ticks_to_event(1, n);
    n = 0;
    for (int i = 0; i < 7; i++) begin
      tick_once((i * 5) % 11, e);
      n++;
      if (i < 6) check(!e, "R8 no event before seventh tick", e, 0);
    end
    check(e, "R8 event on seventh gapped tick", e, 1);
    repeat (20) @(negedge clk);
    check(!timer_event, "R8 idle clocks give no event", timer_event, 0);

    // R2: upper bits ignored
    write_reg(16'hFFFF);
    check(reg_rd_data == 16'h03FF, "R2 upper bits zero", reg_rd_data, 16'h03FF);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule